// File: doc/BRIEF.md
# Trace Enable Qualifier

This block decides, once per clock, whether instruction trace may be emitted. Three conditions are combined by a logical AND: an enabling event computed elsewhere, the state of a start/stop latch (which can be bypassed), and an address-range filter whose sense is either "trace inside the selected ranges" or "trace everywhere except the selected ranges".

The start/stop latch is set by any selected single address comparator match or selected debug watchpoint match. It is cleared by any selected match on the stop side. Its state is exported as a separate resource at all times, whatever the bypass setting. Four configuration registers are loaded through a simple write port. They hold the comparator masks for start and stop, the watchpoint masks for start and stop, the selection of range comparators used by the filter, and the two control bits.

Top module: `trc_enable_qual`

## Requirements
- R1: After an asynchronous reset, `ss_state_o` and `trace_en_o` are 0 and every configuration register holds 0.
- R2: A cycle in which a single address comparator match hits a set bit of the start field (address 0, bits [7:0], bit i selects comparator i), or a watchpoint match hits a set bit of the start field at address 1 (bits [3:0]), sets `ss_state_o` to 1 on the next clock edge, unless R5 applies.
- R3: A cycle in which a match hits a set bit of a stop field (address 0, bits [23:16]; address 1, bits [19:16]) clears `ss_state_o` on the next clock edge.
- R4: Matches on comparators or watchpoints whose mask bits are clear have no effect on `ss_state_o`.
- R5: If start and stop selections both fire in the same cycle, stop wins and `ss_state_o` becomes or remains 0.
- R6: With no selected start or stop match, `ss_state_o` holds its value.
- R7: With control bit 0 (address 3) set, `trace_en_o` can be 1 only while the latch is on. `ss_state_o` always reflects the latch, whatever the value of bit 0.
- R8: With control bit 0 clear, the latch does not gate trace.
- R9: Include mode (address 3 bit 1 = 0): the filter passes only if some range comparator that is selected at address 2 (bits [3:0]) matches. With no comparator selected, it never passes.
- R10: Exclude mode (address 3 bit 1 = 1): the filter passes only if no selected range comparator matches. With no comparator selected, it always passes.
- R11: `trace_en_o` is registered. It equals `event_i` AND the latch condition AND the filter result, all sampled at the previous clock edge, where the latch condition uses the latch state that was held before that edge.
- R12: A register write takes effect at the clock edge that samples it. Matches sampled at that same edge are judged against the old register contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sac_match_i | input | 8 | Single address comparator matches |
| wp_match_i | input | 4 | Debug watchpoint matches |
| arc_match_i | input | 4 | Address range comparator matches |
| event_i | input | 1 | Enabling event result |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 2 | Register select: 0 comparator masks, 1 watchpoint masks, 2 range selection, 3 control |
| cfg_wdata_i | input | 32 | Write data |
| ss_state_o | output | 1 | Start/stop latch state |
| trace_en_o | output | 1 | Registered trace enable |

## Verification
Two functions can fire in the same cycle: a start trigger and a stop trigger, which may come from comparators, from watchpoints, or from one of each. For each of eight mask layouts, the bench sweeps every comparator match pattern together with a watchpoint pattern derived from it. The latch outcome is then judged against the rule that stop wins. A register write that arrives in the same cycle as a match is also provoked, and the expected result is that the old masks still decide that cycle.

// File: rtl/trc_qual_pkg.sv
package trc_qual_pkg;
  localparam int unsigned CFG_AW = 2;
  localparam logic [CFG_AW-1:0] A_SAC_SEL = 2'd0;
  localparam logic [CFG_AW-1:0] A_WP_SEL  = 2'd1;
  localparam logic [CFG_AW-1:0] A_ARC_SEL = 2'd2;
  localparam logic [CFG_AW-1:0] A_CTL     = 2'd3;

  typedef struct packed {
    logic excl;   // 1: filter excludes selected ranges
    logic ss_en;  // 1: latch gates trace
  } ctl_t;
endpackage

// File: rtl/trc_cfg_regs.sv
module trc_cfg_regs
  import trc_qual_pkg::*;
#(
  parameter int unsigned N_SAC   = 8,
  parameter int unsigned N_WP    = 4,
  parameter int unsigned N_ARC   = 4,
  parameter int unsigned FIELD_W = 16,
  parameter int unsigned DATA_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [CFG_AW-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [N_SAC-1:0]  sac_start_o,
  output logic [N_SAC-1:0]  sac_stop_o,
  output logic [N_WP-1:0]   wp_start_o,
  output logic [N_WP-1:0]   wp_stop_o,
  output logic [N_ARC-1:0]  arc_sel_o,
  output ctl_t              ctl_o
);
  localparam int unsigned STOP_LSB = FIELD_W;

  logic unused_wdata;
  assign unused_wdata = ^wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sac_start_o <= '0;
      sac_stop_o  <= '0;
      wp_start_o  <= '0;
      wp_stop_o   <= '0;
      arc_sel_o   <= '0;
      ctl_o       <= '0;
    end else if (we_i) begin
      unique case (addr_i)
        A_SAC_SEL: begin
          sac_start_o <= wdata_i[N_SAC-1:0];
          sac_stop_o  <= wdata_i[STOP_LSB +: N_SAC];
        end
        A_WP_SEL: begin
          wp_start_o <= wdata_i[N_WP-1:0];
          wp_stop_o  <= wdata_i[STOP_LSB +: N_WP];
        end
        A_ARC_SEL: arc_sel_o <= wdata_i[N_ARC-1:0];
        default: begin
          ctl_o.ss_en <= wdata_i[0];
          ctl_o.excl  <= wdata_i[1];
        end
      endcase
    end
  end
endmodule

// File: rtl/trc_startstop.sv
module trc_startstop #(
  parameter int unsigned N_SAC = 8,
  parameter int unsigned N_WP  = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SAC-1:0] sac_match_i,
  input  logic [N_WP-1:0]  wp_match_i,
  input  logic [N_SAC-1:0] sac_start_i,
  input  logic [N_SAC-1:0] sac_stop_i,
  input  logic [N_WP-1:0]  wp_start_i,
  input  logic [N_WP-1:0]  wp_stop_i,
  output logic             state_o
);
  localparam int unsigned N_SRC = N_SAC + N_WP;

  logic [N_SRC-1:0] src, sel_on, sel_off, fire_on, fire_off;
  logic             any_on, any_off;

  assign src     = {wp_match_i, sac_match_i};
  assign sel_on  = {wp_start_i, sac_start_i};
  assign sel_off = {wp_stop_i, sac_stop_i};

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    assign fire_on[g]  = src[g] & sel_on[g];
    assign fire_off[g] = src[g] & sel_off[g];
  end

  assign any_on  = |fire_on;
  assign any_off = |fire_off;

  // stop dominates a simultaneous start
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      state_o <= 1'b0;
    else if (any_off) state_o <= 1'b0;
    else if (any_on)  state_o <= 1'b1;
  end
endmodule

// File: rtl/trc_range_filter.sv
module trc_range_filter #(
  parameter int unsigned N_ARC = 4
) (
  input  logic [N_ARC-1:0] arc_match_i,
  input  logic [N_ARC-1:0] arc_sel_i,
  input  logic             excl_i,
  output logic             pass_o
);
  logic [N_ARC-1:0] hit;

  for (genvar g = 0; g < N_ARC; g++) begin : g_arc
    assign hit[g] = arc_match_i[g] & arc_sel_i[g];
  end

  // empty selection: include never passes, exclude always passes
  assign pass_o = excl_i ? ~(|hit) : (|hit);
endmodule

// File: rtl/trc_enable_qual.sv
module trc_enable_qual
  import trc_qual_pkg::*;
#(
  parameter int unsigned N_SAC   = 8,
  parameter int unsigned N_WP    = 4,
  parameter int unsigned N_ARC   = 4,
  parameter int unsigned FIELD_W = 16,
  parameter int unsigned DATA_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SAC-1:0]  sac_match_i,
  input  logic [N_WP-1:0]   wp_match_i,
  input  logic [N_ARC-1:0]  arc_match_i,
  input  logic              event_i,
  input  logic              cfg_we_i,
  input  logic [1:0]        cfg_addr_i,
  input  logic [DATA_W-1:0] cfg_wdata_i,
  output logic              ss_state_o,
  output logic              trace_en_o
);
  logic [N_SAC-1:0] sac_start, sac_stop;
  logic [N_WP-1:0]  wp_start, wp_stop;
  logic [N_ARC-1:0] arc_sel;
  ctl_t             ctl;
  logic             ss_q, flt_pass, ss_ok, te_d;

  trc_cfg_regs #(
    .N_SAC(N_SAC), .N_WP(N_WP), .N_ARC(N_ARC), .FIELD_W(FIELD_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk_i, .rst_ni,
    .we_i       (cfg_we_i),
    .addr_i     (cfg_addr_i),
    .wdata_i    (cfg_wdata_i),
    .sac_start_o(sac_start),
    .sac_stop_o (sac_stop),
    .wp_start_o (wp_start),
    .wp_stop_o  (wp_stop),
    .arc_sel_o  (arc_sel),
    .ctl_o      (ctl)
  );

  trc_startstop #(.N_SAC(N_SAC), .N_WP(N_WP)) u_ss (
    .clk_i, .rst_ni,
    .sac_match_i,
    .wp_match_i,
    .sac_start_i(sac_start),
    .sac_stop_i (sac_stop),
    .wp_start_i (wp_start),
    .wp_stop_i  (wp_stop),
    .state_o    (ss_q)
  );

  trc_range_filter #(.N_ARC(N_ARC)) u_flt (
    .arc_match_i,
    .arc_sel_i(arc_sel),
    .excl_i   (ctl.excl),
    .pass_o   (flt_pass)
  );

  assign ss_ok = ~ctl.ss_en | ss_q;
  assign te_d  = event_i & ss_ok & flt_pass;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) trace_en_o <= 1'b0;
    else         trace_en_o <= te_d;
  end

  assign ss_state_o = ss_q;
endmodule

// File: rtl/trc_enable_qual_chk.sv
module trc_enable_qual_chk #(
  parameter int unsigned N_SAC = 8,
  parameter int unsigned N_WP  = 4,
  parameter int unsigned N_ARC = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_SAC-1:0] sac_match_i,
  input logic [N_WP-1:0]  wp_match_i,
  input logic             event_i,
  input logic [N_SAC-1:0] sac_start,
  input logic [N_SAC-1:0] sac_stop,
  input logic [N_WP-1:0]  wp_start,
  input logic [N_WP-1:0]  wp_stop,
  input logic [N_ARC-1:0] arc_sel,
  input logic             ss_en,
  input logic             excl,
  input logic             ss_state_o,
  input logic             trace_en_o
);
  logic on_hit, off_hit;
  assign on_hit  = |(sac_match_i & sac_start) | |(wp_match_i & wp_start);
  assign off_hit = |(sac_match_i & sac_stop)  | |(wp_match_i & wp_stop);

  p_start_sets_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    on_hit && !off_hit |=> ss_state_o);
  p_stop_clears_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    off_hit |=> !ss_state_o);
  p_stop_wins_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    on_hit && off_hit |=> !ss_state_o);
  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !on_hit && !off_hit |=> $stable(ss_state_o));
  p_latch_gate_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ss_en && !ss_state_o |=> !trace_en_o);
  p_bypass_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    event_i && !ss_en && excl && arc_sel == '0 |=> trace_en_o);
  p_incl_empty_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !excl && arc_sel == '0 |=> !trace_en_o);
  p_no_event_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !event_i |=> !trace_en_o);
endmodule

bind trc_enable_qual trc_enable_qual_chk #(.N_SAC(N_SAC), .N_WP(N_WP), .N_ARC(N_ARC)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sac_match_i(sac_match_i),
  .wp_match_i (wp_match_i),
  .event_i    (event_i),
  .sac_start  (sac_start),
  .sac_stop   (sac_stop),
  .wp_start   (wp_start),
  .wp_stop    (wp_stop),
  .arc_sel    (arc_sel),
  .ss_en      (ctl.ss_en),
  .excl       (ctl.excl),
  .ss_state_o (ss_state_o),
  .trace_en_o (trace_en_o)
);

// File: tb/trc_enable_qual_test.sv
`timescale 1ns/1ps
module trc_enable_qual_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  sac_match_i = '0;
  logic [3:0]  wp_match_i = '0;
  logic [3:0]  arc_match_i = '0;
  logic        event_i = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [1:0]  cfg_addr_i = '0;
  logic [31:0] cfg_wdata_i = '0;
  logic        ss_state_o, trace_en_o;

  trc_enable_qual uut (.*);

  always #10 clk_i = ~clk_i;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // bench model of configuration and state
  logic [7:0] m_sac_on = '0, m_sac_off = '0;
  logic [3:0] m_wp_on = '0, m_wp_off = '0, m_arc = '0;
  logic       m_ssen = 0, m_excl = 0, m_ss = 0;

  task automatic check(input string tag, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  task automatic step(input logic [7:0] sac, input logic [3:0] wp, input logic [3:0] arc,
                      input logic ev, input logic we, input logic [1:0] wa,
                      input logic [31:0] wd, input string te_tag);
    logic on, off, hit_any, pass, te_m;
    string ss_tag;
    sac_match_i = sac; wp_match_i = wp; arc_match_i = arc; event_i = ev;
    cfg_we_i = we; cfg_addr_i = wa; cfg_wdata_i = wd;
    on  = |(sac & m_sac_on)  | |(wp & m_wp_on);
    off = |(sac & m_sac_off) | |(wp & m_wp_off);
    hit_any = |(arc & m_arc);
    pass = m_excl ? !hit_any : hit_any;
    te_m = ev & (!m_ssen | m_ss) & pass;
    if (on && off)          ss_tag = "R5";
    else if (off)           ss_tag = "R3";
    else if (on)            ss_tag = "R2";
    else if ((sac|wp) != 0) ss_tag = "R4";
    else                    ss_tag = "R6";
    if (we) ss_tag = {ss_tag, "/R12"};
    @(posedge clk_i);
    if (off) m_ss = 0; else if (on) m_ss = 1;
    if (we) begin
      case (wa)
        2'd0: begin m_sac_on = wd[7:0]; m_sac_off = wd[23:16]; end
        2'd1: begin m_wp_on = wd[3:0]; m_wp_off = wd[19:16]; end
        2'd2: m_arc = wd[3:0];
        default: begin m_ssen = wd[0]; m_excl = wd[1]; end
      endcase
    end
    @(negedge clk_i);
    cfg_we_i = 0;
    check(ss_tag, "ss_state_o", ss_state_o, m_ss);
    check(te_tag, "trace_en_o", trace_en_o, te_m);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    step(8'h00, 4'h0, 4'h0, 1'b0, 1'b1, a, d, "R12");
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1", "ss_state_o in reset", ss_state_o, 1'b0);
    check("R1", "trace_en_o in reset", trace_en_o, 1'b0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1", "ss_state_o after reset", ss_state_o, 1'b0);
    // all masks zero after reset: nothing starts, include mode with no range -> no trace
    step(8'hFF, 4'hF, 4'hF, 1'b1, 1'b0, 2'd0, 32'h0, "R1");

    // R12: write a start mask in the same cycle as a matching input
    step(8'h01, 4'h0, 4'h0, 1'b0, 1'b1, 2'd0, 32'h0000_0001, "R12");
    check("R12", "old mask used on write edge", ss_state_o, 1'b0);
    step(8'h01, 4'h0, 4'h0, 1'b0, 1'b0, 2'd0, 32'h0, "R12");

    // latch sweep: gating enabled, filter always passes (exclude, empty selection)
    wr(2'd3, 32'h3);
    wr(2'd2, 32'h0);
    for (int cfg = 0; cfg < 8; cfg++) begin
      wr(2'd0, {8'h0, 8'(1 << ((cfg + 3) % 8)), 8'h0, 8'(1 << cfg) | 8'(cfg == 5 ? 8'h81 : 8'h0)});
      wr(2'd1, {12'h0, 4'(1 << ((cfg + 1) % 4)), 12'h0, 4'(1 << (cfg % 4))});
      for (int p = 0; p < 256; p++) begin
        logic [7:0] pv;
        pv = 8'(p);
        step(pv, pv[7:4] ^ pv[3:0], 4'h0, 1'b1, 1'b0, 2'd0, 32'h0, "R7");
      end
    end

    // filter and gating sweep with the latch off, then on
    wr(2'd0, 32'h0002_0001);
    wr(2'd1, 32'h0);
    for (int l = 0; l < 2; l++) begin
      step(l ? 8'h01 : 8'h02, 4'h0, 4'h0, 1'b0, 1'b0, 2'd0, 32'h0, "R11");
      for (int c = 0; c < 4; c++) begin
        for (int s = 0; s < 16; s++) begin
          wr(2'd3, 32'(c));
          wr(2'd2, 32'(s));
          for (int a = 0; a < 16; a++) begin
            for (int e = 0; e < 2; e++) begin
              string t;
              if (e == 0)        t = "R11";
              else if (c[0])     t = "R7";
              else if (c[1])     t = "R10";
              else               t = "R9";
              if (e == 1 && !c[0] && a == 0) t = "R8";
              step(8'h00, 4'h0, 4'(a), e[0], 1'b0, 2'd0, 32'h0, t);
              // latch state exported regardless of gating bit
              if (a == 15 && e == 1) check("R7", "ss_state_o export", ss_state_o, l[0]);
            end
          end
        end
      end
    end

    done = 1;
    summary();
    $finish;
  end
endmodule